// File: doc/BRIEF.md
# Line Configuration Bank with Hardware Lock

This block holds the configuration for a set of I/O lines, one bit per line in each setting. It covers five settings: whether the line is owned by general-purpose I/O or by a peripheral, multi-drive (open-drain) enable, pull-up enable, the choice between peripheral A and peripheral B, and the polarity used for input-change detection. Software changes each setting through two write addresses. One address sets bits and the other clears them. A third address reads the setting back.

Peripherals can freeze the configuration of their own lines. When a peripheral raises a bit of `lock_req`, the lock bit for that line becomes 1 and stays at 1 until the block's reset is asserted. While a line is locked, writes to its ownership, multi-drive, pull-up and peripheral-select bits are dropped for that line only. The other lines in the same write are still updated. The detection-polarity setting is not covered by the lock.

Top module: `gpio_cfg_lock`

## Requirements
- R1: After reset, `cfg_gpio_own` and `cfg_pull_up` are all ones. `cfg_multi_drv`, `cfg_periph_b`, `cfg_rise_sel` and `lock_status` are all zeros.
- R2: A write to a set address (word address 0 ownership, 3 multi-drive, 6 pull-up, 9 peripheral-B, 12 rising/high polarity) sets each unlocked line whose data bit is 1. Lines whose data bit is 0 keep their value.
- R3: A write to a clear address (1, 4, 7, 10, 13, in the same setting order) clears each unlocked line whose data bit is 1. Lines whose data bit is 0 keep their value.
- R4: `bus_rdata` is combinational from `bus_addr`. Addresses 2, 5, 8, 11 and 14 return the current ownership, multi-drive, pull-up, peripheral-B and polarity bits, with line i on data bit i. Address 15 returns the lock bits. Every set and clear address reads 0. The `cfg_*` outputs always equal the registered settings.
- R5: Line i's lock bit is 1 from the clock edge after `lock_req[i]` is sampled high. No write changes it afterwards.
- R6: For a locked line, a write to any ownership, multi-drive, pull-up or peripheral-select set/clear address leaves that line's bit unchanged. Unlocked lines in the same write are still updated.
- R7: A `lock_req` bit that is high in the same cycle as a configuration write blocks that write for its line.
- R8: A write to address 15 (lock status) changes nothing.
- R9: Polarity bit 0 means falling edge / low level, and 1 means rising edge / high level. Writing mask 0x0000_004A to address 13 puts lines 1, 3 and 6 in falling/low mode. Polarity writes apply to locked lines as well.
- R10: Only the block reset clears the lock bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data, one line per bit |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| lock_req | input | NLINES | Per-line lock requests from peripherals |
| lock_status | output | NLINES | Sticky lock bits |
| cfg_gpio_own | output | NLINES | 1 = line owned by general-purpose I/O |
| cfg_multi_drv | output | NLINES | Multi-drive enable |
| cfg_pull_up | output | NLINES | Pull-up enable |
| cfg_periph_b | output | NLINES | 1 = peripheral B selected, 0 = peripheral A |
| cfg_rise_sel | output | NLINES | 1 = rising/high detection, 0 = falling/low |

## Verification
The case that is hardest to reach from the ports is a single write that touches locked and unlocked lines together, especially when the lock arrives in the same clock edge as the write. The bench locks sparse, irregular line patterns, sometimes through `lock_req` alone and sometimes in the write cycle itself. It then issues all-ones set and clear words to every address and compares each line against an arithmetic model. A long pseudo-random sequence of addresses, data and occasional lock pulses follows, and a mid-run reset shows that the locks are released only by the block reset.

// File: rtl/gcl_pkg.sv
package gcl_pkg;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int NUM_CFG = 5;

    // Each setting k occupies three consecutive word addresses: set, clear, status
    typedef enum logic [ADDR_W-1:0] {
        A_OWN_SET  = 4'd0,  A_OWN_CLR  = 4'd1,  A_OWN_STAT  = 4'd2,
        A_MD_SET   = 4'd3,  A_MD_CLR   = 4'd4,  A_MD_STAT   = 4'd5,
        A_PU_SET   = 4'd6,  A_PU_CLR   = 4'd7,  A_PU_STAT   = 4'd8,
        A_SELB_SET = 4'd9,  A_SELB_CLR = 4'd10, A_SELB_STAT = 4'd11,
        A_RISE_SET = 4'd12, A_RISE_CLR = 4'd13, A_RISE_STAT = 4'd14,
        A_LOCK_STAT = 4'd15
    } gcl_addr_e;

    localparam int F_OWN  = 0;
    localparam int F_MD   = 1;
    localparam int F_PU   = 2;
    localparam int F_SELB = 3;
    localparam int F_RISE = 4;

    // Reset value and lock sensitivity per setting, indexed by field
    localparam logic [NUM_CFG-1:0] FIELD_RST_ONES = 5'b00101;
    localparam logic [NUM_CFG-1:0] FIELD_LOCKABLE = 5'b01111;
endpackage

// File: rtl/gcl_setclr_reg.sv
module gcl_setclr_reg #(
    parameter int NLINES   = 32,
    parameter bit RST_ONES = 1'b0,
    parameter bit LOCKABLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_stb,
    input  logic              clr_stb,
    input  logic [NLINES-1:0] wmask,
    input  logic [NLINES-1:0] hold,
    output logic [NLINES-1:0] q
);
    localparam logic [NLINES-1:0] RST_VAL = RST_ONES ? '1 : '0;

    typedef struct packed {
        logic [NLINES-1:0] val;
    } reg_st_t;

    reg_st_t           st_d, st_q;
    logic [NLINES-1:0] eff_mask;

    always_comb begin
        st_d     = st_q;
        eff_mask = LOCKABLE ? (wmask & ~hold) : wmask;
        if (set_stb) begin
            st_d.val = st_q.val | eff_mask;
        end else if (clr_stb) begin
            st_d.val = st_q.val & ~eff_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{val: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.val;
endmodule

// File: rtl/gcl_lock_bank.sv
module gcl_lock_bank #(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] lock_req,
    output logic [NLINES-1:0] lock_q,
    output logic [NLINES-1:0] lock_eff
);
    typedef struct packed {
        logic [NLINES-1:0] bits;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bits = st_q.bits | lock_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{bits: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_q   = st_q.bits;
    // A request in the current cycle already guards the current write
    assign lock_eff = st_q.bits | lock_req;
endmodule

// File: rtl/gcl_read_mux.sv
module gcl_read_mux
    import gcl_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NUM_CFG*NLINES-1:0] cfg_flat,
    input  logic [NLINES-1:0]         lock_bits,
    output logic [DATA_W-1:0]         rdata
);
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_CFG; k++) begin
            if (addr == ADDR_W'(3 * k + 2)) begin
                rdata[NLINES-1:0] = cfg_flat[k*NLINES +: NLINES];
            end
        end
        if (addr == A_LOCK_STAT) begin
            rdata[NLINES-1:0] = lock_bits;
        end
    end
endmodule

// File: rtl/gpio_cfg_lock.sv
module gpio_cfg_lock
    import gcl_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NLINES-1:0] lock_req,
    output logic [NLINES-1:0] lock_status,
    output logic [NLINES-1:0] cfg_gpio_own,
    output logic [NLINES-1:0] cfg_multi_drv,
    output logic [NLINES-1:0] cfg_pull_up,
    output logic [NLINES-1:0] cfg_periph_b,
    output logic [NLINES-1:0] cfg_rise_sel
);
    logic [NLINES-1:0]         lock_eff;
    logic [NUM_CFG*NLINES-1:0] cfg_flat;
    logic [NLINES-1:0]         wmask;

    assign wmask = bus_wdata[NLINES-1:0];

    gcl_lock_bank #(.NLINES(NLINES)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_req (lock_req),
        .lock_q   (lock_status),
        .lock_eff (lock_eff)
    );

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_field
        logic set_stb, clr_stb;
        assign set_stb = bus_wr && (bus_addr == ADDR_W'(3 * g));
        assign clr_stb = bus_wr && (bus_addr == ADDR_W'(3 * g + 1));

        gcl_setclr_reg #(
            .NLINES   (NLINES),
            .RST_ONES (FIELD_RST_ONES[g]),
            .LOCKABLE (FIELD_LOCKABLE[g])
        ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (set_stb),
            .clr_stb (clr_stb),
            .wmask   (wmask),
            .hold    (lock_eff),
            .q       (cfg_flat[g*NLINES +: NLINES])
        );
    end

    gcl_read_mux #(.NLINES(NLINES)) u_rd (
        .addr      (bus_addr),
        .cfg_flat  (cfg_flat),
        .lock_bits (lock_status),
        .rdata     (bus_rdata)
    );

    assign cfg_gpio_own  = cfg_flat[F_OWN*NLINES  +: NLINES];
    assign cfg_multi_drv = cfg_flat[F_MD*NLINES   +: NLINES];
    assign cfg_pull_up   = cfg_flat[F_PU*NLINES   +: NLINES];
    assign cfg_periph_b  = cfg_flat[F_SELB*NLINES +: NLINES];
    assign cfg_rise_sel  = cfg_flat[F_RISE*NLINES +: NLINES];
endmodule

// File: rtl/gcl_checker.sv
module gcl_checker #(
    parameter int NLINES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [3:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [NLINES-1:0] lock_req,
    input logic [NLINES-1:0] lock_status,
    input logic [NLINES-1:0] cfg_gpio_own,
    input logic [NLINES-1:0] cfg_multi_drv,
    input logic [NLINES-1:0] cfg_pull_up,
    input logic [NLINES-1:0] cfg_periph_b,
    input logic [NLINES-1:0] cfg_rise_sel
);
    logic [4*NLINES-1:0] guarded;
    logic [NLINES-1:0]   hold_now;
    assign guarded  = {cfg_gpio_own, cfg_multi_drv, cfg_pull_up, cfg_periph_b};
    assign hold_now = lock_status | lock_req;

    // R10: lock bits never fall while reset is released
    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(lock_status) & ~lock_status) == '0));

    // R5: a sampled request shows up as a lock bit one edge later
    assert_lock_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|lock_req) |=> ((lock_status & $past(lock_req)) == $past(lock_req)));

    // R6 and R7: guarded bits of held lines do not move
    assert_locked_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((guarded ^ $past(guarded)) & {4{$past(hold_now)}}) == '0));

    // R2 and R3: without a write nothing changes
    assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(guarded) && $stable(cfg_rise_sel)));

    // R9: a rising-select write applies even to locked lines
    assert_rise_unmasked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd12) |=>
        ((cfg_rise_sel & $past(bus_wdata[NLINES-1:0])) == $past(bus_wdata[NLINES-1:0])));

    // R8: a write to the lock status address leaves the settings alone
    assert_lockaddr_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'd15) |=> ($stable(guarded) && $stable(cfg_rise_sel)));
endmodule

bind gpio_cfg_lock gcl_checker #(.NLINES(NLINES)) u_gcl_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .lock_req      (lock_req),
    .lock_status   (lock_status),
    .cfg_gpio_own  (cfg_gpio_own),
    .cfg_multi_drv (cfg_multi_drv),
    .cfg_pull_up   (cfg_pull_up),
    .cfg_periph_b  (cfg_periph_b),
    .cfg_rise_sel  (cfg_rise_sel)
);

// File: tb/tb_gpio_cfg_lock.sv
module tb_gpio_cfg_lock;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  lock_req = '0;
    logic [N-1:0]  lock_status, cfg_gpio_own, cfg_multi_drv, cfg_pull_up, cfg_periph_b, cfg_rise_sel;

    always #10 clk = ~clk;

    gpio_cfg_lock #(.NLINES(N)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_req(lock_req),
        .lock_status(lock_status), .cfg_gpio_own(cfg_gpio_own),
        .cfg_multi_drv(cfg_multi_drv), .cfg_pull_up(cfg_pull_up),
        .cfg_periph_b(cfg_periph_b), .cfg_rise_sel(cfg_rise_sel)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [N-1:0] m_cfg [5];
    logic [N-1:0] m_lock;
    logic [31:0]  rng = 32'h1234_5678;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cfg[0] = '1; m_cfg[1] = '0; m_cfg[2] = '1; m_cfg[3] = '0; m_cfg[4] = '0;
        m_lock = '0;
    endtask

    task automatic check_all(input string req);
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            bus_addr = 4'(3 * k + 2); #1;
            chk({req, " R4 status"}, bus_rdata, 32'(m_cfg[k]));
            bus_addr = 4'(3 * k); #1;
            chk({req, " R4 set-addr reads 0"}, bus_rdata, 32'h0);
        end
        bus_addr = 4'd15; #1;
        chk({req, " R5 lock read"}, bus_rdata, 32'(m_lock));
        chk({req, " R4 port own"}, 32'(cfg_gpio_own), 32'(m_cfg[0]));
        chk({req, " R4 port md"}, 32'(cfg_multi_drv), 32'(m_cfg[1]));
        chk({req, " R4 port pu"}, 32'(cfg_pull_up), 32'(m_cfg[2]));
        chk({req, " R4 port selb"}, 32'(cfg_periph_b), 32'(m_cfg[3]));
        chk({req, " R9 port rise"}, 32'(cfg_rise_sel), 32'(m_cfg[4]));
        chk({req, " R10 port lock"}, 32'(lock_status), 32'(m_lock));
    endtask

    task automatic cycle(input logic we, input logic [3:0] a, input logic [31:0] d, input logic [N-1:0] lr);
        logic [N-1:0] held, mask;
        int k, op;
        @(negedge clk);
        bus_wr = we; bus_addr = a; bus_wdata = d; lock_req = lr;
        @(posedge clk);
        held = m_lock | lr;
        k = int'(a) / 3; op = int'(a) % 3;
        if (we && a != 4'd15 && op != 2) begin
            mask = d[N-1:0] & ((k < 4) ? ~held : '1);
            if (op == 0) m_cfg[k] = m_cfg[k] | mask;
            else         m_cfg[k] = m_cfg[k] & ~mask;
        end
        m_lock = m_lock | lr;
        @(negedge clk);
        bus_wr = 1'b0; lock_req = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y = x;
        y ^= y << 13; y ^= y >> 17; y ^= y << 5;
        return y;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // R2/R3: walking and sparse patterns on every set/clear pair, no locks
        for (int k = 0; k < 5; k++) begin
            cycle(1'b1, 4'(3 * k), 32'h8000_0001 << (k % 2), '0);
            check_all("R2 set");
            cycle(1'b1, 4'(3 * k + 1), 32'h0000_00FF, '0);
            check_all("R3 clear");
            cycle(1'b1, 4'(3 * k), 32'h0, '0);
            check_all("R2 zero word");
        end
        cycle(1'b1, 4'd12, 32'hFFFF_FFFF, '0);
        cycle(1'b1, 4'd13, 32'h0000_004A, '0);
        check_all("R9 falling mask 4A");

        // R5: lock by request alone
        cycle(1'b0, 4'd0, 32'h0, 32'h0000_F00F);
        check_all("R5 lock capture");

        // R6: all-ones on every guarded address with locks present
        for (int a = 0; a < 15; a++) begin
            cycle(1'b1, 4'(a), 32'hFFFF_FFFF, '0);
            check_all("R6 masked write");
        end

        // R7: lock arrives with the write
        cycle(1'b1, 4'd1, 32'hFFFF_FFFF, 32'h00FF_0000);
        check_all("R7 same-cycle lock");
        cycle(1'b1, 4'd0, 32'hFFFF_FFFF, 32'h0300_0000);
        check_all("R7 same-cycle lock set");

        // R8: lock status address ignores writes
        cycle(1'b1, 4'd15, 32'h0000_0000, '0);
        check_all("R8 write zero");
        cycle(1'b1, 4'd15, 32'hFFFF_FFFF, '0);
        check_all("R8 write ones");

        // R9: polarity on locked lines
        cycle(1'b1, 4'd13, 32'hFFFF_FFFF, '0);
        check_all("R9 fall on locked");
        cycle(1'b1, 4'd12, 32'h0000_F00F, '0);
        check_all("R9 rise on locked");

        // Pseudo-random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] d;
            logic [N-1:0] lr;
            rng = nxt(rng); d = nxt(rng);
            lr = (rng[7:5] == 3'd0) ? (N'(1) << rng[12:8]) : '0;
            cycle(rng[4], rng[3:0], d, lr);
            rng = d;
            check_all("R6 random");
        end

        // R10: only reset clears locks
        do_reset();
        check_all("R10 reset clears lock");
        cycle(1'b1, 4'd1, 32'hFFFF_FFFF, '0);
        check_all("R10 unlocked after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule